// File: doc/BRIEF.md
# Buffer Address Generator

This block turns one buffer memory instruction into per-lane virtual addresses for a 64-lane wavefront. At a start pulse it captures the buffer descriptor fields (base, stride, record count, tiling enable with its index-stride and element-size codes, and the lane-number-in-index option), the scalar offset, the instruction's immediate offset and the caller's execute mask. It then walks the lanes one per cycle. For each lane it reads that lane's vector index and vector offset through a lane-select read port, forms a buffer offset in either linear or tiled form, adds the base and scalar offset, and checks the buffer offset against the range limit.

Each active lane yields one address result tagged with its lane number and an out-of-range flag. When the walk ends, the block reports the out-of-range lane mask and a narrowed execute mask for the memory access, which is the captured mask with those lanes cleared. The caller's own mask is never altered, so it is still intact once the access completes.

Top module: `buf_addr_gen`

## Requirements
- R1: After reset `busy`, `outValid` and `done` are low and `oobMask` and `accessMask` are zero.
- R2: A `start` seen while idle captures all job inputs; `busy` then stays high for exactly 64 cycles while `laneSel` steps 0,1,...,63, one lane per cycle; a `start` seen while busy is ignored, and input changes after capture do not affect the job.
- R3: Exactly one result (`outValid` high for one cycle) appears for each lane whose captured execute-mask bit is 1, in increasing lane order, with `outLane` equal to the lane number, one cycle after that lane is selected; inactive lanes produce no result.
- R4: In linear mode (`tileEn`=0) the lane offset is `laneOff`+`immOff`, the buffer offset is lane offset + `stride`*lane index, and `outAddr` = `baseAddr` + `scalarOff` + buffer offset (modulo 2^48).
- R5: The lane index is `laneIdx` plus the lane number when `addLaneId`=1, and `laneIdx` alone when it is 0.
- R6: In tiled mode (`tileEn`=1), with index stride 2^(3+`idxStrideSel`) (codes 0..3 give 8,16,32,64) and element size 2^(1+`elemSizeSel`) (codes 0..3 give 2,4,8,16), the buffer offset is ((index/idxStride)*`stride` + (offset/elemSize)*elemSize)*idxStride + (index%idxStride)*elemSize + offset%elemSize.
- R7: The range limit is `numRecords` when `stride` is 0 and `numRecords`*`stride` otherwise; `outOob` is 1 exactly when the buffer offset is greater than or equal to that limit.
- R8: `done` pulses for one cycle, in the same cycle as the lane-63 result slot; `oobMask` then holds a 1 for each active out-of-range lane and `accessMask` equals the captured execute mask with those bits cleared; both hold until the next accepted start.
- R9: An inactive lane never sets its `oobMask` bit, even when its index and offset lie outside the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| execMask | input | 64 | Caller's execute mask, one bit per lane |
| baseAddr | input | 48 | Descriptor base address |
| stride | input | 14 | Descriptor record stride in bytes |
| numRecords | input | 32 | Descriptor record count |
| tileEn | input | 1 | 1 selects the tiled address form |
| idxStrideSel | input | 2 | Index stride code (8 << code) |
| elemSizeSel | input | 2 | Element size code (2 << code) |
| addLaneId | input | 1 | Add the lane number to the index |
| scalarOff | input | 32 | Scalar offset |
| immOff | input | 12 | Instruction immediate offset |
| busy | output | 1 | A job is walking the lanes |
| laneSel | output | 6 | Lane whose vector operands are read this cycle |
| laneIdx | input | 32 | Vector index of lane `laneSel` |
| laneOff | input | 32 | Vector offset of lane `laneSel` |
| outValid | output | 1 | A lane result is present |
| outLane | output | 6 | Lane number of the result |
| outAddr | output | 48 | Virtual address of the result lane |
| outOob | output | 1 | Result lane is out of range |
| done | output | 1 | Last lane slot of the job |
| oobMask | output | 64 | Out-of-range active lanes |
| accessMask | output | 64 | Execute mask to use for the access |

## Verification
The assertions take for granted that `laneIdx` and `laneOff` answer for the current `laneSel` within the same cycle, and that the lane data stays fixed for the whole job. They also assume that no intermediate product or sum wraps past 48 bits, because the out-of-range compare is only meaningful on unwrapped offsets. The bench keeps within these bounds: it serves lane data from a combinational array indexed by `laneSel`, refills that array only between jobs, and picks index, offset, stride and record values small enough that every term stays far below 2^48.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_RUN  = 1'b1
  } ctrlState_t;

  // Strobes from the lane sequencer to the datapath
  typedef struct packed {
    logic load;   // capture job inputs this edge
    logic step;   // a lane is being processed this cycle
    logic last;   // the lane being processed is the final one
  } laneStrobe_t;

  // Tile index stride = 8 << code
  function automatic logic [2:0] idxShiftOf(input logic [1:0] code);
    return 3'(code) + 3'd3;
  endfunction

  // Element size = 2 << code
  function automatic logic [2:0] elemShiftOf(input logic [1:0] code);
    return 3'(code) + 3'd1;
  endfunction

endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
  import bag_pkg::*;
#(
  parameter int LANES = 64,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic [LANE_W-1:0] laneSel,
  output laneStrobe_t       strobe
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  ctrlState_t        state;
  logic [LANE_W-1:0] laneCnt;

  assign busy    = (state == CTRL_RUN);
  assign laneSel = laneCnt;

  always_comb begin
    strobe.load = start && (state == CTRL_IDLE);
    strobe.step = (state == CTRL_RUN);
    strobe.last = (state == CTRL_RUN) && (laneCnt == LAST_LANE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= CTRL_IDLE;
      laneCnt <= '0;
    end else begin
      unique case (state)
        CTRL_IDLE: begin
          laneCnt <= '0;
          if (start) state <= CTRL_RUN;
        end
        CTRL_RUN: begin
          if (laneCnt == LAST_LANE) begin
            state   <= CTRL_IDLE;
            laneCnt <= '0;
          end else begin
            laneCnt <= laneCnt + 1'b1;
          end
        end
        default: state <= CTRL_IDLE;
      endcase
    end
  end

  // R2: lanes advance by one per busy cycle
  p_lane_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.last) |=> (laneSel == LANE_W'($past(laneSel) + 1'b1)));

  // R2: a start seen mid-walk does not end or restart the job
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !strobe.last) |=> (busy && laneSel != '0));

  // R2: the walk ends after the final lane
  p_walk_ends_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> !busy);

endmodule

// File: rtl/bag_datapath.sv
module bag_datapath
  import bag_pkg::*;
#(
  parameter int LANES    = 64,
  parameter int ADDR_W   = 48,
  parameter int VAL_W    = 32,
  parameter int STRIDE_W = 14,
  parameter int REC_W    = 32,
  parameter int SOFF_W   = 32,
  parameter int IMM_W    = 12,
  localparam int LANE_W  = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneStrobe_t         strobe,
  input  logic [LANE_W-1:0]   laneSel,
  input  logic [LANES-1:0]    execMask,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [REC_W-1:0]    numRecords,
  input  logic                tileEn,
  input  logic [1:0]          idxStrideSel,
  input  logic [1:0]          elemSizeSel,
  input  logic                addLaneId,
  input  logic [SOFF_W-1:0]   scalarOff,
  input  logic [IMM_W-1:0]    immOff,
  input  logic [VAL_W-1:0]    laneIdx,
  input  logic [VAL_W-1:0]    laneOff,
  output logic                outValid,
  output logic [LANE_W-1:0]   outLane,
  output logic [ADDR_W-1:0]   outAddr,
  output logic                outOob,
  output logic                done,
  output logic [LANES-1:0]    oobMask,
  output logic [LANES-1:0]    accessMask
);

  // Captured job state
  logic [ADDR_W-1:0]   baseReg;
  logic [STRIDE_W-1:0] strideReg;
  logic [ADDR_W-1:0]   limitReg;
  logic                tileReg;
  logic [2:0]          idxShReg;
  logic [2:0]          elemShReg;
  logic                laneIdReg;
  logic [SOFF_W-1:0]   soffReg;
  logic [IMM_W-1:0]    immReg;
  logic [LANES-1:0]    execReg;

  // Per-lane arithmetic
  logic [ADDR_W-1:0] strideExt;
  logic [ADDR_W-1:0] idxFull;
  logic [ADDR_W-1:0] offFull;
  logic [ADDR_W-1:0] idxHi, idxLo, offHi, offLo;
  logic [ADDR_W-1:0] linearOff, tiledOff, bufOff;
  logic [ADDR_W-1:0] laneAddr;
  logic              laneActive;
  logic              laneOob;
  logic [LANES-1:0]  oobNext;
  logic [ADDR_W-1:0] loadLimit;

  // Range limit from the incoming descriptor
  always_comb begin
    if (stride == '0) loadLimit = ADDR_W'(numRecords);
    else              loadLimit = ADDR_W'(numRecords) * ADDR_W'(stride);
  end

  always_comb begin
    strideExt = ADDR_W'(strideReg);
    idxFull   = ADDR_W'(laneIdx) + (laneIdReg ? ADDR_W'(laneSel) : '0);
    offFull   = ADDR_W'(laneOff) + ADDR_W'(immReg);

    idxHi = idxFull >> idxShReg;
    idxLo = idxFull & ((ADDR_W'(1) << idxShReg) - ADDR_W'(1));
    offHi = offFull >> elemShReg;
    offLo = offFull & ((ADDR_W'(1) << elemShReg) - ADDR_W'(1));

    linearOff = offFull + strideExt * idxFull;
    tiledOff  = ((idxHi * strideExt + (offHi << elemShReg)) << idxShReg)
              + (idxLo << elemShReg) + offLo;

    bufOff     = tileReg ? tiledOff : linearOff;
    laneAddr   = baseReg + ADDR_W'(soffReg) + bufOff;
    laneActive = execReg[laneSel];
    laneOob    = (bufOff >= limitReg);
  end

  always_comb begin
    oobNext = oobMask;
    if (strobe.step && laneActive && laneOob) oobNext[laneSel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg    <= '0;
      strideReg  <= '0;
      limitReg   <= '0;
      tileReg    <= 1'b0;
      idxShReg   <= 3'd3;
      elemShReg  <= 3'd1;
      laneIdReg  <= 1'b0;
      soffReg    <= '0;
      immReg     <= '0;
      execReg    <= '0;
      outValid   <= 1'b0;
      outLane    <= '0;
      outAddr    <= '0;
      outOob     <= 1'b0;
      done       <= 1'b0;
      oobMask    <= '0;
      accessMask <= '0;
    end else begin
      outValid <= 1'b0;
      outOob   <= 1'b0;
      done     <= 1'b0;
      if (strobe.load) begin
        baseReg    <= baseAddr;
        strideReg  <= stride;
        limitReg   <= loadLimit;
        tileReg    <= tileEn;
        idxShReg   <= idxShiftOf(idxStrideSel);
        elemShReg  <= elemShiftOf(elemSizeSel);
        laneIdReg  <= addLaneId;
        soffReg    <= scalarOff;
        immReg     <= immOff;
        execReg    <= execMask;
        oobMask    <= '0;
        accessMask <= '0;
      end
      if (strobe.step) begin
        outValid <= laneActive;
        outLane  <= laneSel;
        outAddr  <= laneAddr;
        outOob   <= laneActive && laneOob;
        oobMask  <= oobNext;
      end
      if (strobe.last) begin
        done       <= 1'b1;
        accessMask <= execReg & ~oobNext;
      end
    end
  end

  // R3: results are produced only for active lanes
  p_valid_active_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> execReg[outLane]);

  // R7: a flagged result is recorded in the running mask
  p_oob_recorded_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOob) |-> oobMask[outLane]);

  // R9: inactive lanes never appear in the out-of-range mask
  p_inactive_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    (oobMask & ~execReg) == '0);

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: the access mask and out-of-range mask partition the captured mask
  p_access_split_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (((accessMask | oobMask) == execReg) && ((accessMask & oobMask) == '0)));

endmodule

// File: rtl/buf_addr_gen.sv
module buf_addr_gen
  import bag_pkg::*;
#(
  parameter int LANES    = 64,
  parameter int ADDR_W   = 48,
  parameter int VAL_W    = 32,
  parameter int STRIDE_W = 14,
  parameter int REC_W    = 32,
  parameter int SOFF_W   = 32,
  parameter int IMM_W    = 12,
  localparam int LANE_W  = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [LANES-1:0]    execMask,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [REC_W-1:0]    numRecords,
  input  logic                tileEn,
  input  logic [1:0]          idxStrideSel,
  input  logic [1:0]          elemSizeSel,
  input  logic                addLaneId,
  input  logic [SOFF_W-1:0]   scalarOff,
  input  logic [IMM_W-1:0]    immOff,
  output logic                busy,
  output logic [LANE_W-1:0]   laneSel,
  input  logic [VAL_W-1:0]    laneIdx,
  input  logic [VAL_W-1:0]    laneOff,
  output logic                outValid,
  output logic [LANE_W-1:0]   outLane,
  output logic [ADDR_W-1:0]   outAddr,
  output logic                outOob,
  output logic                done,
  output logic [LANES-1:0]    oobMask,
  output logic [LANES-1:0]    accessMask
);

  laneStrobe_t strobe;

  bag_ctrl #(.LANES(LANES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .busy    (busy),
    .laneSel (laneSel),
    .strobe  (strobe)
  );

  bag_datapath #(
    .LANES    (LANES),
    .ADDR_W   (ADDR_W),
    .VAL_W    (VAL_W),
    .STRIDE_W (STRIDE_W),
    .REC_W    (REC_W),
    .SOFF_W   (SOFF_W),
    .IMM_W    (IMM_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .laneSel      (laneSel),
    .execMask     (execMask),
    .baseAddr     (baseAddr),
    .stride       (stride),
    .numRecords   (numRecords),
    .tileEn       (tileEn),
    .idxStrideSel (idxStrideSel),
    .elemSizeSel  (elemSizeSel),
    .addLaneId    (addLaneId),
    .scalarOff    (scalarOff),
    .immOff       (immOff),
    .laneIdx      (laneIdx),
    .laneOff      (laneOff),
    .outValid     (outValid),
    .outLane      (outLane),
    .outAddr      (outAddr),
    .outOob       (outOob),
    .done         (done),
    .oobMask      (oobMask),
    .accessMask   (accessMask)
  );

endmodule

// File: tb/test_buf_addr_gen.sv
module test_buf_addr_gen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [63:0] execMask;
  logic [47:0] baseAddr;
  logic [13:0] stride;
  logic [31:0] numRecords;
  logic        tileEn;
  logic [1:0]  idxStrideSel;
  logic [1:0]  elemSizeSel;
  logic        addLaneId;
  logic [31:0] scalarOff;
  logic [11:0] immOff;
  logic        busy;
  logic [5:0]  laneSel;
  logic [31:0] laneIdx;
  logic [31:0] laneOff;
  logic        outValid;
  logic [5:0]  outLane;
  logic [47:0] outAddr;
  logic        outOob;
  logic        done;
  logic [63:0] oobMask;
  logic [63:0] accessMask;

  logic [31:0] idxMem [64];
  logic [31:0] offMem [64];

  // Job copy used by the reference model
  logic [63:0] jExec;
  logic [47:0] jBase;
  logic [13:0] jStride;
  logic [31:0] jRec;
  logic        jTile;
  logic [1:0]  jIsSel;
  logic [1:0]  jEsSel;
  logic        jTid;
  logic [31:0] jSoff;
  logic [11:0] jImm;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always_comb begin
    laneIdx = idxMem[laneSel];
    laneOff = offMem[laneSel];
  end

  buf_addr_gen i_buf_addr_gen (
    .clk(clk), .rstN(rstN), .start(start), .execMask(execMask),
    .baseAddr(baseAddr), .stride(stride), .numRecords(numRecords),
    .tileEn(tileEn), .idxStrideSel(idxStrideSel), .elemSizeSel(elemSizeSel),
    .addLaneId(addLaneId), .scalarOff(scalarOff), .immOff(immOff),
    .busy(busy), .laneSel(laneSel), .laneIdx(laneIdx), .laneOff(laneOff),
    .outValid(outValid), .outLane(outLane), .outAddr(outAddr), .outOob(outOob),
    .done(done), .oobMask(oobMask), .accessMask(accessMask)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] refBufOff(input int l);
    logic [63:0] idx, off, ih, il, oh, ol;
    int is, es;
    idx = 64'(idxMem[l]) + (jTid ? 64'(l) : 64'd0);
    off = 64'(offMem[l]) + 64'(jImm);
    if (jTile) begin
      is = 3 + int'(jIsSel);
      es = 1 + int'(jEsSel);
      ih = idx >> is;
      il = idx & ((64'd1 << is) - 64'd1);
      oh = off >> es;
      ol = off & ((64'd1 << es) - 64'd1);
      return ((ih * 64'(jStride) + (oh << es)) << is) + (il << es) + ol;
    end
    return off + 64'(jStride) * idx;
  endfunction

  function automatic logic [63:0] refLimit();
    if (jStride == 0) return 64'(jRec);
    return 64'(jRec) * 64'(jStride);
  endfunction

  function automatic logic [47:0] refAddr(input int l);
    return 48'(64'(jBase) + 64'(jSoff) + refBufOff(l));
  endfunction

  // Launch a job with the current port values and verify every cycle of it.
  // injectAt >= 0 pulses start with a changed stride at that busy cycle.
  task automatic runJob(input string req, input int injectAt);
    int nextLane = 0;
    int selExp = 0;
    int busyCnt = 0;
    bit gotDone = 0;
    logic [63:0] expOob = '0;
    logic [63:0] expAcc;
    logic [63:0] holdOob, holdAcc;
    for (int l = 0; l < 64; l++)
      if (execMask[l] && refBufOff(l) >= refLimit()) expOob[l] = 1'b1;
    expAcc = execMask & ~expOob;
    jExec = execMask; jBase = baseAddr; jStride = stride; jRec = numRecords;
    jTile = tileEn; jIsSel = idxStrideSel; jEsSel = elemSizeSel;
    jTid = addLaneId; jSoff = scalarOff; jImm = immOff;
    expOob = '0;
    for (int l = 0; l < 64; l++)
      if (jExec[l] && refBufOff(l) >= refLimit()) expOob[l] = 1'b1;
    expAcc = jExec & ~expOob;

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    for (int c = 0; c < 120 && !gotDone; c++) begin
      if (c > 0) @(negedge clk);
      if (c == injectAt) begin
        start = 1'b1;
        stride = stride + 14'd7;
        execMask = ~execMask;
      end else begin
        start = 1'b0;
      end
      if (busy) begin
        if (laneSel !== 6'(selExp))
          check(0, "R2 lane order", 64'(laneSel), 64'(selExp));
        selExp++;
        busyCnt++;
      end
      if (outValid) begin
        while (nextLane < 64 && !jExec[nextLane]) nextLane++;
        check(outLane === 6'(nextLane), {req, " R3 lane"}, 64'(outLane), 64'(nextLane));
        check(outAddr === refAddr(nextLane), {req, " address"},
              64'(outAddr), 64'(refAddr(nextLane)));
        check(outOob === expOob[nextLane], {req, " R7 range flag"},
              64'(outOob), 64'(expOob[nextLane]));
        nextLane++;
      end
      if (done) begin
        gotDone = 1;
        check(oobMask === expOob, "R8 oobMask at done", oobMask, expOob);
        check(accessMask === expAcc, "R8 accessMask at done", accessMask, expAcc);
      end
    end
    start = 1'b0;
    while (nextLane < 64 && !jExec[nextLane]) nextLane++;
    check(nextLane == 64, "R3 every active lane reported", 64'(nextLane), 64'd64);
    check(gotDone, "R8 done seen", 64'(gotDone), 64'd1);
    check(busyCnt == 64, "R2 busy length", 64'(busyCnt), 64'd64);
    holdOob = oobMask;
    holdAcc = accessMask;
    @(negedge clk);
    check(done === 1'b0 && outValid === 1'b0 && busy === 1'b0, "R8 single done pulse",
          {61'd0, done, outValid, busy}, 64'd0);
    check(oobMask === holdOob && accessMask === holdAcc, "R8 masks held",
          oobMask ^ holdOob, 64'd0);
  endtask

  task automatic testReset();
    check(busy === 1'b0 && outValid === 1'b0 && done === 1'b0, "R1 reset controls",
          {61'd0, busy, outValid, done}, 64'd0);
    check(oobMask === 64'd0 && accessMask === 64'd0, "R1 reset masks",
          oobMask | accessMask, 64'd0);
  endtask

  // R4 linear form, all lanes active, upper lanes cross the limit (R7)
  task automatic testLinear();
    for (int l = 0; l < 64; l++) begin
      idxMem[l] = 32'(l);
      offMem[l] = 32'(l * 4);
    end
    execMask = '1; baseAddr = 48'h1000_0000; stride = 14'd16; numRecords = 32'd40;
    tileEn = 1'b0; addLaneId = 1'b0; scalarOff = 32'h100; immOff = 12'd8;
    runJob("R4 linear", -1);
  endtask

  // R5 lane number in index, R7 stride zero limit, R9 inactive lanes out of range
  task automatic testLaneIdZeroStride();
    for (int l = 0; l < 64; l++) begin
      idxMem[l] = 32'((l * 5) % 13);
      offMem[l] = (l % 4 == 1) ? 32'd50000 : 32'((l * 9) % 300);
    end
    execMask = 64'hA5A5_0F0F_3C3C_EEEE & ~64'h2222_2222_2222_2222;
    baseAddr = 48'h0000_ABCD_0000; stride = 14'd0; numRecords = 32'd200;
    tileEn = 1'b0; addLaneId = 1'b1; scalarOff = 32'd12; immOff = 12'd3;
    runJob("R5 R9 stride zero", -1);
  endtask

  // R6 tiled, index stride 16, element size 8
  task automatic testTiledA();
    for (int l = 0; l < 64; l++) begin
      idxMem[l] = 32'((l * 7) % 41);
      offMem[l] = 32'((l * 13) % 57);
    end
    execMask = 64'hFFFF_FFFF_0000_FFFF; baseAddr = 48'h20_0000; stride = 14'd32;
    numRecords = 32'd30; tileEn = 1'b1; idxStrideSel = 2'd1; elemSizeSel = 2'd2;
    addLaneId = 1'b0; scalarOff = 32'd64; immOff = 12'd5;
    runJob("R6 tiled 16/8", -1);
  endtask

  // R6 tiled, index stride 64, element size 2, with lane number (R5)
  task automatic testTiledB();
    for (int l = 0; l < 64; l++) begin
      idxMem[l] = 32'((l * 11) % 90);
      offMem[l] = 32'((l * 3) % 23);
    end
    execMask = 64'h7FFF_FFFF_FFFF_FFFE; baseAddr = 48'h8000_0000_0000; stride = 14'd12;
    numRecords = 32'd100; tileEn = 1'b1; idxStrideSel = 2'd3; elemSizeSel = 2'd0;
    addLaneId = 1'b1; scalarOff = 32'hFFFF; immOff = 12'hFFF;
    runJob("R6 tiled 64/2", -1);
  endtask

  // R2 start during a walk is ignored, later input changes have no effect
  task automatic testStartWhileBusy();
    for (int l = 0; l < 64; l++) begin
      idxMem[l] = 32'(63 - l);
      offMem[l] = 32'(l * 2);
    end
    execMask = 64'h0123_4567_89AB_CDEF; baseAddr = 48'h4000; stride = 14'd8;
    numRecords = 32'd48; tileEn = 1'b0; addLaneId = 1'b0; scalarOff = 32'd0; immOff = 12'd0;
    runJob("R2 start ignored", 10);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; execMask = '0; baseAddr = '0; stride = '0;
    numRecords = '0; tileEn = 1'b0; idxStrideSel = '0; elemSizeSel = '0;
    addLaneId = 1'b0; scalarOff = '0; immOff = '0;
    for (int l = 0; l < 64; l++) begin
      idxMem[l] = '0;
      offMem[l] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLinear();
    testLaneIdZeroStride();
    testTiledA();
    testTiledB();
    testStartWhileBusy();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule